// File: doc/BRIEF.md
# Wake-up GPIO edge status register

This block watches sixteen general-purpose input pins while the system sleeps and keeps a sticky record of which pins produced an edge that should wake it. Three per-pin masks arrive as inputs: a wake-source enable, a rising-edge enable and a falling-edge enable. Each pin is brought into the clock domain through a two-flop synchronizer. It is then compared against its value one cycle earlier, and a qualifying edge sets that pin's status bit. The bit stays set until software clears it or a reset removes it.

Software sees the status as one 32-bit register at byte offset 0x18 of its peripheral window, reached through a single-cycle strobe interface. A written one clears the matching bit. Any of three independent active-low reset sources (hardware, watchdog, GPIO) empties the register. A single wake request output is high while any status bit is set, and the power sequencer outside this block consumes it.

Top module: `wake_edge_status`

## Requirements
- R1: Status bit n sits at register bit n for n = 0..15. A read strobe (`bus_sel`=1, `bus_we`=0, `bus_addr`=0x18) returns {16'h0000, status} on `bus_rdata` in the cycle after the strobe. Bits 31..16 always read 0. A read at any other address, and an idle cycle, return 0.
- R2: A status bit is never set by a pin that holds a steady level, whatever the masks are.
- R3: With its wake enable and rising-edge enable at 1, a pin's 0-to-1 transition sets its status bit.
- R4: With its wake enable and falling-edge enable at 1, a pin's 1-to-0 transition sets its status bit. A rising transition on a pin whose rising-edge enable is 0 sets nothing.
- R5: A pin whose wake enable is 0 never sets its status bit, on either edge.
- R6: A write strobe to 0x18 clears every status bit whose `bus_wdata` bit is 1 and leaves the bits written 0 unchanged. Bits 31..16 of the written data have no effect. A write to any other address changes nothing.
- R7: A low `rst_n`, `wdt_rst_n` or `gpio_rst_n` at a rising clock edge clears all status bits.
- R8: When a qualifying edge and a write-one clear reach the same bit at the same clock edge, the bit ends up set.
- R9: `wake_req` is 1 exactly while at least one status bit is 1.
- R10: A pin transition that is present before rising clock edge k becomes visible in the status at edge k+2. A pin level that is already present when `rst_n` is released sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous; also clears synchronizers |
| wdt_rst_n | input | 1 | Watchdog reset, active low; clears status |
| gpio_rst_n | input | 1 | GPIO reset, active low; clears status |
| gpio_in | input | 16 | Asynchronous pin levels |
| wake_en | input | 16 | Per-pin wake-source enable |
| rise_en | input | 16 | Per-pin rising-edge enable |
| fall_en | input | 16 | Per-pin falling-edge enable |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the peripheral window |
| bus_wdata | input | 32 | Write data; ones clear status bits |
| bus_rdata | output | 32 | Registered read data |
| wake_req | output | 1 | High while any status bit is set |

## Verification
The bench targets a clear and an edge that land on the same bit at the same edge. A design that lets the clear win loses that wake event. It holds pins high across the release of reset. A synchronizer that comes out of reset at zero reports a false rising edge unless edge detection waits for the pipeline to fill. It samples one cycle before and at the expected latency, which exposes a missing or extra synchronizer stage. It also writes to reserved bits and to a neighbouring address and drives the watchdog and GPIO resets on their own. A decoder that ignored the address, or a reset that was not wired, would then leave bits set or clear them wrongly.

// File: rtl/wake_edge_pkg.sv
// Shared definitions for the wake-up edge status register.
// Assumes: one register per instance, byte addressing on the access port.
package wake_edge_pkg;

    // Decoded kind of access in a given cycle.
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_op_e;

    // Default geometry of the block.
    localparam int unsigned PINS_DEFAULT   = 16;
    localparam int unsigned DATA_W_DEFAULT = 32;
    localparam int unsigned ADDR_W_DEFAULT = 8;
    localparam int unsigned STAGES_DEFAULT = 2;

endpackage

// File: rtl/wes_sync.sv
// Pin synchronizer for the wake edge status register.
// Brings WIDTH asynchronous pins into the clock domain through STAGES flops.
// Also keeps a one-cycle-delayed copy of the synchronized value for edge
// comparison. 'primed' rises once the synchronized value and its delayed copy
// both hold real pin samples, so levels present at reset are not taken as edges.
// Assumes: synchronous active-low reset; STAGES >= 2.
module wes_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] sync_q,
    output logic [WIDTH-1:0] prev_q,
    output logic             primed
);

    localparam int unsigned FILL  = STAGES + 1;
    localparam int unsigned CNT_W = $clog2(FILL + 1);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [CNT_W-1:0] fill_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // Capture the raw pin levels.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= din;
                end
            end else begin : g_next
                // Pass the sample one flop further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= '0;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_q = stage_q[STAGES-1];

    // Hold the previous synchronized value for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q;
    end

    // Count cycles since reset until the whole pipeline holds pin samples.
    always_ff @(posedge clk) begin
        if (!rst_n)                           fill_q <= '0;
        else if (fill_q != CNT_W'(FILL))      fill_q <= fill_q + 1'b1;
    end

    assign primed = (fill_q == CNT_W'(FILL));

endmodule

// File: rtl/wes_edge_qual.sv
// Edge qualification for the wake edge status register.
// Per pin: flags a rising or falling transition between the delayed and the
// current synchronized value, and keeps it only if the pin is a wake source
// and the matching edge enable is set. Purely combinational.
// Assumes: inputs come from wes_sync; primed gates out pre-fill transitions.
module wes_edge_qual #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] sync_q,
    input  logic [WIDTH-1:0] prev_q,
    input  logic             primed,
    input  logic [WIDTH-1:0] wake_en,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] set_vec
);

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_pin
            logic went_up;
            logic went_down;

            // Classify the transition seen on this pin in this cycle.
            always_comb begin
                went_up   = sync_q[i] & ~prev_q[i];
                went_down = ~sync_q[i] & prev_q[i];
            end

            // Keep only transitions the masks ask for.
            always_comb begin
                set_vec[i] = primed & wake_en[i] &
                             ((rise_en[i] & went_up) | (fall_en[i] & went_down));
            end
        end
    endgenerate

endmodule

// File: rtl/wes_status_reg.sv
// Sticky status bits for the wake edge status register.
// A bit is set by set_vec and cleared by clr_vec; set has priority so an edge
// arriving with a clear is kept. Any of the three reset inputs empties it.
// Assumes: all resets synchronous and active low.
module wes_status_reg #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_rst_n,
    input  logic             gpio_rst_n,
    input  logic [WIDTH-1:0] set_vec,
    input  logic [WIDTH-1:0] clr_vec,
    output logic [WIDTH-1:0] status_q
);

    logic any_rst;

    // Merge the independent reset sources.
    always_comb begin
        any_rst = ~rst_n | ~wdt_rst_n | ~gpio_rst_n;
    end

    // Update the sticky bits: reset, then set over clear.
    always_ff @(posedge clk) begin
        if (any_rst) status_q <= '0;
        else         status_q <= (status_q & ~clr_vec) | set_vec;
    end

endmodule

// File: rtl/wake_edge_status.sv
// Wake-up GPIO edge status register, top level.
// Synchronizes the pins, qualifies edges against the three masks, keeps the
// sticky status and serves a single-cycle strobe port at REG_OFFSET.
// Read data is registered (valid the cycle after the strobe); reserved bits
// read zero; written ones clear status bits; wake_req is the OR of status.
// Assumes: masks are driven from registers elsewhere; synchronous active-low resets.
module wake_edge_status
    import wake_edge_pkg::*;
#(
    parameter int unsigned     NUM_PINS    = PINS_DEFAULT,
    parameter int unsigned     DATA_W      = DATA_W_DEFAULT,
    parameter int unsigned     ADDR_W      = ADDR_W_DEFAULT,
    parameter int unsigned     SYNC_STAGES = STAGES_DEFAULT,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wdt_rst_n,
    input  logic                gpio_rst_n,
    input  logic [NUM_PINS-1:0] gpio_in,
    input  logic [NUM_PINS-1:0] wake_en,
    input  logic [NUM_PINS-1:0] rise_en,
    input  logic [NUM_PINS-1:0] fall_en,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                wake_req
);

    localparam int unsigned RSV_W = DATA_W - NUM_PINS;

    bus_op_e             op;
    logic [NUM_PINS-1:0] sync_q;
    logic [NUM_PINS-1:0] prev_q;
    logic                primed;
    logic [NUM_PINS-1:0] set_vec;
    logic [NUM_PINS-1:0] clr_vec;
    logic [NUM_PINS-1:0] status_q;
    logic                unused_rsv_wdata;

    // Decode the access kind for this cycle.
    always_comb begin
        op = BUS_IDLE;
        if (bus_sel && (bus_addr == REG_OFFSET)) begin
            op = bus_we ? BUS_WRITE : BUS_READ;
        end
    end

    // Ones in the low write data become clear requests.
    always_comb begin
        clr_vec = (op == BUS_WRITE) ? bus_wdata[NUM_PINS-1:0] : '0;
    end

    // Reserved write bits are accepted and dropped.
    assign unused_rsv_wdata = ^bus_wdata[DATA_W-1:NUM_PINS];

    wes_sync #(
        .WIDTH  (NUM_PINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (gpio_in),
        .sync_q (sync_q),
        .prev_q (prev_q),
        .primed (primed)
    );

    wes_edge_qual #(
        .WIDTH (NUM_PINS)
    ) u_qual (
        .sync_q  (sync_q),
        .prev_q  (prev_q),
        .primed  (primed),
        .wake_en (wake_en),
        .rise_en (rise_en),
        .fall_en (fall_en),
        .set_vec (set_vec)
    );

    wes_status_reg #(
        .WIDTH (NUM_PINS)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .wdt_rst_n  (wdt_rst_n),
        .gpio_rst_n (gpio_rst_n),
        .set_vec    (set_vec),
        .clr_vec    (clr_vec),
        .status_q   (status_q)
    );

    // Register read data; zero outside a matching read.
    always_ff @(posedge clk) begin
        if (!rst_n)              bus_rdata <= '0;
        else if (op == BUS_READ) bus_rdata <= {{RSV_W{1'b0}}, status_q};
        else                     bus_rdata <= '0;
    end

    // Request wake-up while any status bit is held.
    assign wake_req = |status_q;

endmodule

// File: rtl/wake_edge_status_chk.sv
// Assertion checker for wake_edge_status, attached with bind below.
// Observes only the top-level ports.
module wake_edge_status_chk #(
    parameter int unsigned       NUM_PINS   = 16,
    parameter int unsigned       DATA_W     = 32,
    parameter int unsigned       ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wdt_rst_n,
    input logic                gpio_rst_n,
    input logic [NUM_PINS-1:0] wake_en,
    input logic [NUM_PINS-1:0] rise_en,
    input logic [NUM_PINS-1:0] fall_en,
    input logic                bus_sel,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [NUM_PINS-1:0] wdata_lo,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                wake_req
);

    // R1: reserved read bits are always zero.
    a_r1_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:NUM_PINS] == '0);

    // R5: with no wake sources, an empty register stays empty.
    a_r5_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!wake_req && wake_en == '0) |=> !wake_req);

    // R6: clearing every bit with no edge enabled empties the register.
    a_r6_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && bus_addr == REG_OFFSET && (&wdata_lo)
         && rise_en == '0 && fall_en == '0) |=> !wake_req);

    // R7: watchdog or GPIO reset empties the register.
    a_r7_aux_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdt_rst_n || !gpio_rst_n) |=> !wake_req);

    // R9: a new wake request needs some enabled wake source.
    a_r9_rise_needs_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_req) |-> ($past(wake_en) != '0));

endmodule

bind wake_edge_status wake_edge_status_chk #(
    .NUM_PINS   (NUM_PINS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wdt_rst_n  (wdt_rst_n),
    .gpio_rst_n (gpio_rst_n),
    .wake_en    (wake_en),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wdata_lo   (bus_wdata[NUM_PINS-1:0]),
    .bus_rdata  (bus_rdata),
    .wake_req   (wake_req)
);

// File: tb/wake_edge_status_bench.sv
`timescale 1ns/1ps
module wake_edge_status_bench;

    localparam real         HALF     = 2.5;
    localparam int          WD_CYC   = 150000;
    localparam logic [7:0]  OFF      = 8'h18;

    logic        clk = 1'b0;
    logic        rst_n, wdt_rst_n, gpio_rst_n;
    logic [15:0] gpio_in, wake_en, rise_en, fall_en;
    logic        bus_sel, bus_we;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wake_req;

    int n_checks = 0;
    int n_err    = 0;

    // Reference state computed from the requirements.
    logic [15:0] m_h1, m_h2, m_h3, m_status;
    logic [31:0] m_rd;
    int          m_fill;

    always #(HALF) clk = ~clk;

    wake_edge_status u_wake_edge_status (
        .clk(clk), .rst_n(rst_n), .wdt_rst_n(wdt_rst_n), .gpio_rst_n(gpio_rst_n),
        .gpio_in(gpio_in), .wake_en(wake_en), .rise_en(rise_en), .fall_en(fall_en),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake_req(wake_req)
    );

    function automatic logic [15:0] qual_set(input logic [15:0] cur, prev,
                                             input logic [15:0] we, re, fe);
        return we & ((re & cur & ~prev) | (fe & ~cur & prev));
    endfunction

    task automatic check(input string req, input logic [31:0] act, exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: update the model at the edge, return at the next falling edge.
    task automatic tick();
        logic [15:0] clr_v, set_v;
        logic        wr_hit, rd_hit;
        @(posedge clk);
        wr_hit = bus_sel && bus_we && bus_addr == OFF;
        rd_hit = bus_sel && !bus_we && bus_addr == OFF;
        clr_v  = wr_hit ? bus_wdata[15:0] : 16'h0;
        set_v  = (m_fill == 3) ? qual_set(m_h2, m_h3, wake_en, rise_en, fall_en) : 16'h0;
        if (!rst_n) begin
            m_h1 = 0; m_h2 = 0; m_h3 = 0; m_fill = 0; m_status = 0; m_rd = 0;
        end else begin
            m_rd     = rd_hit ? {16'h0, m_status} : 32'h0;
            m_status = (!wdt_rst_n || !gpio_rst_n) ? 16'h0 : ((m_status & ~clr_v) | set_v);
            m_h3 = m_h2; m_h2 = m_h1; m_h1 = gpio_in;
            if (m_fill < 3) m_fill++;
        end
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 0; bus_we = 0; bus_wdata = 0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_we = 0; bus_addr = a;
        tick();
        bus_sel = 0;
        d = bus_rdata;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(WD_CYC * 2 * HALF);
        n_err++; n_checks++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        rst_n = 0; wdt_rst_n = 1; gpio_rst_n = 1;
        gpio_in = 16'h00FF; wake_en = 16'hFFFF; rise_en = 16'hFFFF; fall_en = 16'hFFFF;
        bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
        m_h1 = 0; m_h2 = 0; m_h3 = 0; m_status = 0; m_rd = 0; m_fill = 0;
        @(negedge clk);
        ticks(3);
        check("R7 reset state wake_req", {31'h0, wake_req}, 32'h0);
        check("R1 reset state rdata", bus_rdata, 32'h0);
        rst_n = 1;
        // R10: levels held through reset release set nothing.
        ticks(6);
        do_read(OFF, rd);
        check("R10 level at reset release", rd, 32'h0);

        // R3 and R10: rising edge, exact latency.
        fall_en = 16'h0;
        gpio_in = gpio_in | 16'h0100;
        ticks(2);
        check("R10 not yet visible", {31'h0, wake_req}, 32'h0);
        tick();
        check("R10 visible at third edge", {31'h0, wake_req}, 32'h1);
        do_read(OFF, rd);
        check("R3 rising edge sets bit 8", rd, 32'h0000_0100);

        // R6: zeros, other address, then the real clear.
        do_write(OFF, 32'h0000_0000);
        do_write(8'h1C, 32'h0000_FFFF);
        do_read(OFF, rd);
        check("R6 zero write and other address ignored", rd, 32'h0000_0100);
        do_write(OFF, 32'h0000_0100);
        do_read(OFF, rd);
        check("R6 one clears bit", rd, 32'h0);

        // R4: falling enable only; rising edge on bit 9 must not set.
        rise_en = 16'h0; fall_en = 16'h0001;
        gpio_in = (gpio_in & ~16'h0001) | 16'h0200;
        ticks(4);
        do_read(OFF, rd);
        check("R4 falling edge only", rd, 32'h0000_0001);
        do_write(OFF, 32'hFFFF);

        // R5: wake enable off for bit 2.
        wake_en = ~16'h0004; rise_en = 16'hFFFF; fall_en = 16'hFFFF;
        gpio_in = gpio_in ^ 16'h0004;
        ticks(4);
        do_read(OFF, rd);
        check("R5 disabled source", rd, 32'h0);

        // R2: static levels with everything enabled.
        wake_en = 16'hFFFF;
        ticks(10);
        do_read(OFF, rd);
        check("R2 steady level", rd, 32'h0);

        // R8: clear lands at the same edge as the set.
        gpio_in = gpio_in ^ 16'h0008;
        ticks(2);
        do_write(OFF, 32'h0000_0008);
        check("R8 set wins wake_req", {31'h0, wake_req}, 32'h1);
        do_read(OFF, rd);
        check("R8 set wins over clear", rd, 32'h0000_0008);

        // R7: watchdog reset.
        wdt_rst_n = 0; tick(); wdt_rst_n = 1;
        do_read(OFF, rd);
        check("R7 watchdog reset clears", rd, 32'h0);
        // R7: GPIO reset.
        gpio_in = gpio_in ^ 16'h0010; ticks(4);
        gpio_rst_n = 0; tick(); gpio_rst_n = 1;
        do_read(OFF, rd);
        check("R7 gpio reset clears", rd, 32'h0);
        // R7: hardware reset.
        gpio_in = gpio_in ^ 16'h0020; ticks(4);
        check("R9 wake_req with bit set", {31'h0, wake_req}, 32'h1);
        rst_n = 0; tick(); rst_n = 1;
        check("R7 hw reset clears wake_req", {31'h0, wake_req}, 32'h0);

        // R1 and R6: reserved write bits and foreign read address.
        ticks(4);
        gpio_in = gpio_in ^ 16'h0020; ticks(4);
        do_write(OFF, 32'hFFFF_0000);
        do_read(OFF, rd);
        check("R6 reserved write ignored", rd, 32'h0000_0020);
        do_read(8'h1C, rd);
        check("R1 other address reads zero", rd, 32'h0);

        // Random phase against the reference model.
        for (int c = 0; c < 4000; c++) begin
            if (c % 50 == 0) begin
                wake_en = 16'($urandom); rise_en = 16'($urandom); fall_en = 16'($urandom);
            end
            if ($urandom % 4 == 0) gpio_in = gpio_in ^ 16'($urandom & $urandom & $urandom);
            bus_sel = 0; bus_we = 0; bus_wdata = 0;
            case ($urandom % 10)
                0, 1: begin bus_sel = 1; bus_we = 1; bus_wdata = $urandom & $urandom;
                            bus_addr = ($urandom % 5 == 0) ? 8'h14 : OFF; end
                2, 3, 4: begin bus_sel = 1; bus_addr = ($urandom % 5 == 0) ? 8'h1C : OFF; end
                default: ;
            endcase
            wdt_rst_n  = ($urandom % 300 != 0);
            gpio_rst_n = ($urandom % 300 != 0);
            rst_n      = ($urandom % 700 != 0);
            tick();
            check("R9 wake_req vs status", {31'h0, wake_req}, {31'h0, |m_status});
            check("R1 read data vs status", bus_rdata, m_rd);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule